// File: doc/BRIEF.md
# Disk Controller Configuration Header Registers

This block holds the 16-byte configuration header of a dual-channel disk controller function. A configuration access port reaches it one dword at a time. Reads return the identity fields, the command and status words, the class and programming-interface bytes, and the latency timer. Writes change only the few writable bits, and they honour per-byte enables. The rest of the controller raises single-cycle event pulses that set sticky status bits, and software clears those bits by writing ones.

Two strap inputs are sampled while reset is held. They give the start-up operating mode of each channel: 0 selects compatibility mode and 1 selects native mode. Software may later change each mode bit. The block drives out the I/O decode enable, the bus-master enable and the two channel mode bits. The DMA engine uses the bus-master enable as the gate for starting scatter/gather transfers.

The access port follows valid/ready rules:
- A request is accepted on a rising edge where `req_valid` and `req_ready` are both high.
- A write takes effect at that edge and produces no response.
- A read places its data on `rsp_rdata` with `rsp_valid` high from the next cycle on.
- While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response holds steady.

Top module: `stor_cfg_regs`

## Requirements
- R1: `req_ready` is low exactly while a read response is pending and `rsp_ready` is low. The read response appears in the cycle after acceptance. It holds its data unchanged until `rsp_ready` is high.
- R2: Dword 0 reads {device ID, vendor ID}, taken from parameters. Dword 2 bits 7:0 read the revision parameter, and bits 31:16 read 16'h0101 (base class 01h, sub class 01h). Writes to these fields are ignored.
- R3: Command word (dword 1, bits 15:0) layout:
  - Bit 0 is the I/O enable and bit 2 is the bus-master enable. Both are writable through byte enable 0 and reset to 0.
  - Bit 7 always reads 1 and every other bit reads 0.
  - `io_en_o` and `bm_en_o` follow bits 0 and 2.
- R4: Status word (dword 1, bits 31:16) fixed fields: bit 7 reads 1, bits 10:9 read 01, and bit 11 reads 0. After reset the status word reads 16'h0280.
- R5: A pulse on `evt_i[k]` sets a sticky status bit, with k=0→bit 8, 1→bit 12, 2→bit 13, 3→bit 14 and 4→bit 15.
- R6: A write to dword 1 with byte enable 3 clears each sticky bit whose data bit is 1. If an event and a clear reach the same bit in the same cycle, the bit stays set.
- R7: The programming-interface byte (dword 2, bits 15:8) reads 8'h8A OR'd with the primary mode in bit 0 and the secondary mode in bit 2.
- R8: While reset is held, primary mode loads `strap_i[0]` and secondary mode loads `strap_i[1]`. A write to dword 2 with byte enable 1 loads them from data bits 8 and 10. `chan_native_o[0]` and `chan_native_o[1]` follow the primary and secondary modes.
- R9: The latency timer (dword 3, bits 15:8) is writable through byte enable 1 and resets to 0. All other bits of dword 3 read 0.
- R10: A write with a byte-enable bit clear leaves every bit of that byte unchanged.
- R11: Dword indices 4 and above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; straps sampled while high |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Dword index into configuration space |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 32 | Read data |
| evt_i | input | 5 | Status event pulses |
| strap_i | input | NUM_CH | Power-up mode straps |
| io_en_o | output | 1 | I/O decode enable |
| bm_en_o | output | 1 | Bus-master (scatter/gather) enable |
| chan_native_o | output | NUM_CH | Per-channel native-mode select |

## Verification
The hardest case to reach is an event pulse and a write-one clear landing on the same sticky bit at the same clock edge. A clear normally lags the event by several cycles, so the collision does not arise on its own. The bench drives the clear write and the event pulse together at the same falling edge so that both meet one rising edge. It then reads the status back to confirm that the set won. A second hard case comes from holding `rsp_ready` low while a new read waits. The bench checks that the pending data stays fixed and that the waiting request is accepted only once the response drains.

// File: rtl/stor_cfg_pkg.sv
package stor_cfg_pkg;
  localparam int DW_W       = 32;
  localparam int NUM_STICKY = 5;

  localparam logic [15:0] STS_FIXED  = 16'h0280; // devsel=01, fast b2b capable
  localparam logic [15:0] CMD_FIXED  = 16'h0080; // address stepping
  localparam logic [7:0]  PI_FIXED   = 8'h8A;    // bus-master capable + both programmable
  localparam logic [7:0]  CLASS_BASE = 8'h01;
  localparam logic [7:0]  CLASS_SUB  = 8'h01;

  localparam int CMD_IO_BIT = 0;
  localparam int CMD_BM_BIT = 2;

  typedef enum logic [1:0] {
    DW_IDENT  = 2'd0,
    DW_CMDSTS = 2'd1,
    DW_CLASS  = 2'd2,
    DW_MISC   = 2'd3
  } dw_sel_e;

  // status bit position for each event input
  function automatic int sticky_pos(input int k);
    case (k)
      0:       return 8;
      1:       return 12;
      2:       return 13;
      3:       return 14;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/cfg_access_port.sv
module cfg_access_port (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        req_ready,
  output logic        req_fire,
  input  logic        rsp_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  input  logic [31:0] rd_data_i
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (req_fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_data_i;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_ctrl_regs.sv
module cfg_ctrl_regs #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] strap_i,
  input  logic              cmd_we,
  input  logic              io_wbit,
  input  logic              bm_wbit,
  input  logic              mode_we,
  input  logic [NUM_CH-1:0] mode_wbits,
  input  logic              lat_we,
  input  logic [7:0]        lat_wbyte,
  output logic              io_en,
  output logic              bm_en,
  output logic [NUM_CH-1:0] mode_q,
  output logic [7:0]        lat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      io_en <= 1'b0;
      bm_en <= 1'b0;
    end else if (cmd_we) begin
      io_en <= io_wbit;
      bm_en <= bm_wbit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         lat_q <= '0;
    else if (lat_we) lat_q <= lat_wbyte;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    always_ff @(posedge clk) begin
      if (rst)          mode_q[c] <= strap_i[c];
      else if (mode_we) mode_q[c] <= mode_wbits[c];
    end
  end
endmodule

// File: rtl/cfg_status_regs.sv
module cfg_status_regs
  import stor_cfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_STICKY-1:0] evt_i,
  input  logic                  clr_we,
  input  logic [15:0]           clr_mask,
  output logic [15:0]           sts_o
);
  logic [NUM_STICKY-1:0] sticky_q;

  for (genvar k = 0; k < NUM_STICKY; k++) begin : g_sticky
    localparam int P = sticky_pos(k);
    always_ff @(posedge clk) begin
      if (rst) sticky_q[k] <= 1'b0;
      else     sticky_q[k] <= evt_i[k] | (sticky_q[k] & ~(clr_we & clr_mask[P]));
    end
  end

  always_comb begin
    sts_o = STS_FIXED;
    for (int k = 0; k < NUM_STICKY; k++) sts_o[sticky_pos(k)] = sticky_q[k];
  end
endmodule

// File: rtl/stor_cfg_regs.sv
module stor_cfg_regs
  import stor_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          NUM_CH    = 2,
  parameter logic [15:0] VENDOR_ID = 16'hFACE,
  parameter logic [15:0] DEVICE_ID = 16'h0C0D,
  parameter logic [7:0]  REV_ID    = 8'h06
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [3:0]            req_be,
  input  logic [31:0]           req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  input  logic [NUM_STICKY-1:0] evt_i,
  input  logic [NUM_CH-1:0]     strap_i,
  output logic                  io_en_o,
  output logic                  bm_en_o,
  output logic [NUM_CH-1:0]     chan_native_o
);
  localparam int SEL_W = 2;

  logic          req_fire;
  logic          in_hdr;
  dw_sel_e       sel;
  logic          wr_fire;
  logic [15:0]   sts_q;
  logic [7:0]    lat_q;
  logic [NUM_CH-1:0] mode_q;
  logic [NUM_CH-1:0] mode_wbits;
  logic [7:0]    progif;
  logic [15:0]   cmd_word;
  logic [31:0]   rd_data;

  assign in_hdr  = (req_addr >> SEL_W) == '0;
  assign sel     = dw_sel_e'(req_addr[SEL_W-1:0]);
  assign wr_fire = req_fire && req_write && in_hdr;

  cfg_access_port u_port (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .req_fire(req_fire),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rd_data_i(rd_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mw
    assign mode_wbits[c] = req_wdata[8 + 2*c];
  end

  cfg_ctrl_regs #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst(rst), .strap_i(strap_i),
    .cmd_we(wr_fire && sel == DW_CMDSTS && req_be[0]),
    .io_wbit(req_wdata[CMD_IO_BIT]), .bm_wbit(req_wdata[CMD_BM_BIT]),
    .mode_we(wr_fire && sel == DW_CLASS && req_be[1]),
    .mode_wbits(mode_wbits),
    .lat_we(wr_fire && sel == DW_MISC && req_be[1]),
    .lat_wbyte(req_wdata[15:8]),
    .io_en(io_en_o), .bm_en(bm_en_o), .mode_q(mode_q), .lat_q(lat_q)
  );

  cfg_status_regs u_sts (
    .clk(clk), .rst(rst), .evt_i(evt_i),
    .clr_we(wr_fire && sel == DW_CMDSTS && req_be[3]),
    .clr_mask(req_wdata[31:16]),
    .sts_o(sts_q)
  );

  always_comb begin
    progif = PI_FIXED;
    for (int c = 0; c < NUM_CH; c++) progif[2*c] = mode_q[c];
    cmd_word = CMD_FIXED;
    cmd_word[CMD_IO_BIT] = io_en_o;
    cmd_word[CMD_BM_BIT] = bm_en_o;
  end

  always_comb begin
    rd_data = '0;
    if (in_hdr) begin
      unique case (sel)
        DW_IDENT:  rd_data = {DEVICE_ID, VENDOR_ID};
        DW_CMDSTS: rd_data = {sts_q, cmd_word};
        DW_CLASS:  rd_data = {CLASS_BASE, CLASS_SUB, progif, REV_ID};
        DW_MISC:   rd_data = {16'h0000, lat_q, 8'h00};
        default:   rd_data = '0;
      endcase
    end
  end

  assign chan_native_o = mode_q;
endmodule

// File: rtl/stor_cfg_checker.sv
module stor_cfg_checker
  import stor_cfg_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic [3:0]            req_be,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [31:0]           rsp_rdata,
  input logic [NUM_STICKY-1:0] evt_i,
  input logic [15:0]           sts_q,
  input logic [NUM_CH-1:0]     strap_i,
  input logic                  io_en_o,
  input logic                  bm_en_o,
  input logic [NUM_CH-1:0]     chan_native_o
);
  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_read_resp_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> rsp_valid);

  assert_cmd_reset_R3: assert property (@(posedge clk)
    $past(rst) |-> (!io_en_o && !bm_en_o));

  assert_strap_load_R8: assert property (@(posedge clk)
    $past(rst) |-> (chan_native_o == $past(strap_i)));

  assert_fixed_status_R4: assert property (@(posedge clk) disable iff (rst)
    (sts_q[11:9] == 3'b001) && sts_q[7]);

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && req_write && req_be[1]) |=> $stable(chan_native_o));

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && req_write && req_be[0]) |=> ($stable(io_en_o) && $stable(bm_en_o)));

  for (genvar k = 0; k < NUM_STICKY; k++) begin : g_evt
    assert_sticky_set_R5: assert property (@(posedge clk) disable iff (rst)
      evt_i[k] |=> sts_q[sticky_pos(k)]);
  end
endmodule

bind stor_cfg_regs stor_cfg_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_be(req_be), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .evt_i(evt_i),
  .sts_q(sts_q), .strap_i(strap_i), .io_en_o(io_en_o),
  .bm_en_o(bm_en_o), .chan_native_o(chan_native_o)
);

// File: tb/test_stor_cfg_regs.sv
module test_stor_cfg_regs;
  localparam int ADDR_W = 6;
  localparam logic [31:0] ID_DW = 32'h0C0DFACE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_be = '0;
  logic [31:0] req_wdata = '0;
  logic [4:0] evt_i = '0;
  logic [1:0] strap_i = 2'b01;
  logic req_ready, rsp_valid, io_en_o, bm_en_o;
  logic [31:0] rsp_rdata;
  logic [1:0] chan_native_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  stor_cfg_regs i_stor_cfg_regs (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .evt_i(evt_i), .strap_i(strap_i),
    .io_en_o(io_en_o), .bm_en_o(bm_en_o), .chan_native_o(chan_native_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk); rst = 1'b1; strap_i = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = '0;
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset(2'b01);
    chk("R3 io_en reset", {31'd0, io_en_o}, 32'd0);
    chk("R3 bm_en reset", {31'd0, bm_en_o}, 32'd0);
    chk("R8 strap 01", {30'd0, chan_native_o}, 32'd1);
    do_read(1, d); chk("R4 cmd/status reset", d, 32'h02800080);
    do_read(2, d); chk("R7 progif strap 01", d, 32'h01018B06);
    do_read(3, d); chk("R9 latency reset", d, 32'h0);
  endtask

  task automatic t_identity();
    logic [31:0] d;
    do_read(0, d); chk("R2 ident", d, ID_DW);
    do_write(0, 4'hF, 32'hFFFFFFFF);
    do_read(0, d); chk("R2 ident after write", d, ID_DW);
    do_write(2, 4'b1101, 32'hFFFFFFFF);
    do_read(2, d); chk("R2 class after write", d, 32'h01018B06);
  endtask

  task automatic t_command();
    logic [31:0] d;
    do_write(1, 4'b0001, 32'hFFFFFFFF);
    do_read(1, d); chk("R3 cmd all ones", d, 32'h02800085);
    chk("R3 io_en set", {31'd0, io_en_o}, 32'd1);
    chk("R3 bm_en set", {31'd0, bm_en_o}, 32'd1);
    do_write(1, 4'b0010, 32'h00000000);
    chk("R10 cmd byte0 not enabled", {30'd0, bm_en_o, io_en_o}, 32'd3);
    do_write(1, 4'b0001, 32'h00000004);
    chk("R3 io off bm on", {30'd0, bm_en_o, io_en_o}, 32'd2);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); evt_i = 5'b00011;
    @(negedge clk); evt_i = '0;
    do_read(1, d); chk("R5 evt0/evt1 set", d[31:16], 32'h1380);
    @(negedge clk); evt_i = 5'b11100;
    @(negedge clk); evt_i = '0;
    do_read(1, d); chk("R5 all events", d[31:16], 32'hF380);
    do_write(1, 4'b0111, 32'hFFFF0000);
    do_read(1, d); chk("R10 clear without be3", d[31:16], 32'hF380);
    do_write(1, 4'b1000, 32'h01000000);
    do_read(1, d); chk("R6 clear bit8", d[31:16], 32'hF280);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 1; req_be = 4'b1000;
    req_wdata = 32'h10000000; evt_i = 5'b00010;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_be = '0; evt_i = '0;
    do_read(1, d); chk("R6 set wins over clear", d[31:16], 32'hF280);
    do_write(1, 4'b1000, 32'hFFFF0000);
    do_read(1, d); chk("R6 clear all sticky", d[31:16], 32'h0280);
  endtask

  task automatic t_progif();
    logic [31:0] d;
    do_reset(2'b10);
    chk("R8 strap 10", {30'd0, chan_native_o}, 32'd2);
    do_read(2, d); chk("R7 progif strap 10", d[15:8], 32'h8E);
    do_write(2, 4'b0010, 32'h00000100);
    chk("R8 mode write", {30'd0, chan_native_o}, 32'd1);
    do_read(2, d); chk("R7 progif after write", d[15:8], 32'h8B);
    do_write(2, 4'b1101, 32'h00000400);
    chk("R10 mode be1 clear", {30'd0, chan_native_o}, 32'd1);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    do_write(3, 4'hF, 32'hFFFFFFFF);
    do_read(3, d); chk("R9 latency write", d, 32'h0000FF00);
    do_write(3, 4'b1101, 32'h00000000);
    do_read(3, d); chk("R10 latency be1 clear", d, 32'h0000FF00);
    do_read(4, d); chk("R11 dword4 reads 0", d, 32'h0);
    do_read(7'(ADDR_W'(5)), d); chk("R11 dword5 reads 0", d, 32'h0);
    do_write(5, 4'hF, 32'h00000000);
    do_write(4, 4'hF, 32'h00000000);
    do_read(3, d); chk("R11 alias write ignored", d, 32'h0000FF00);
    chk("R11 modes unchanged", {30'd0, chan_native_o}, 32'd1);
  endtask

  task automatic t_backpressure();
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 0;
    @(negedge clk);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk("R1 req_ready low", {31'd0, req_ready}, 32'd0);
    chk("R1 rdata", rsp_rdata, ID_DW);
    req_addr = 2;
    repeat (2) @(negedge clk);
    chk("R1 rdata held", rsp_rdata, ID_DW);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 second read after drain", rsp_rdata[31:16], 32'h0101);
    @(negedge clk);
    chk("R1 response retired", {31'd0, rsp_valid}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_identity();
    t_command();
    t_status();
    t_progif();
    t_misc();
    t_backpressure();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule